// File: doc/BRIEF.md
# Multi-Format NaN Classifier

This block looks at one floating-point operand per cycle and says whether it is a NaN and, if so, whether it is quiet or signaling. The operand arrives on a 64-bit bus with a two-bit format select. The select picks half precision, bfloat16, single precision or double precision. For the narrower formats the value sits in the low bits of the bus. The classification itself is purely combinational. The three result flags and a valid strobe are then registered, so each answer appears one clock after its operand.

Two runtime controls set how the top fraction bit is read. With the polarity control low, a set top fraction bit marks a quiet NaN. With it high, the meaning is swapped and a set top fraction bit marks a signaling NaN. A separate mode control treats every NaN as quiet. In that mode the block never reports a signaling NaN, whichever polarity is chosen.

Top module: `fp_nan_sorter`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after a clock edge at which `in_valid` was low. The result flags for an operand appear together with its `out_valid`.
- R2: `out_is_nan` is 1 exactly when the exponent field is all ones and the fraction field is nonzero. Infinities (all-ones exponent, zero fraction) and finite values give 0. The sign bit has no effect.
- R3: Format codes and field positions are: `in_fmt`=0 half (exponent [14:10], fraction [9:0]); 1 bfloat16 (exponent [14:7], fraction [6:0]); 2 single (exponent [30:23], fraction [22:0]); 3 double (exponent [62:52], fraction [51:0]). Operand bits above the selected format's width are ignored.
- R4: With `qbit_inverted`=0 and `all_quiet`=0, a NaN whose top fraction bit is 1 reports quiet. A NaN whose top fraction bit is 0 reports signaling.
- R5: With `qbit_inverted`=1 and `all_quiet`=0, a NaN whose top fraction bit is 1 reports signaling. A NaN whose top fraction bit is 0 (with the rest of the fraction nonzero) reports quiet.
- R6: With `all_quiet`=1, `out_is_signaling` is 0 and `out_is_quiet` equals `out_is_nan`, for either polarity.
- R7: `out_is_quiet` and `out_is_signaling` are never both 1. Either of them being 1 implies `out_is_nan` is 1.
- R8: While `in_valid` is low, the three result flags keep their previous values.
- R9: A synchronous active-high `rst` clears `out_valid` and all three result flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and controls are present this cycle |
| in_fmt | input | 2 | Format code (0 half, 1 bfloat16, 2 single, 3 double) |
| in_operand | input | 64 | Operand, right-aligned for narrow formats |
| qbit_inverted | input | 1 | 1: a set top fraction bit means signaling |
| all_quiet | input | 1 | 1: every NaN is reported as quiet |
| out_valid | output | 1 | Registered result is for a new operand |
| out_is_nan | output | 1 | Operand was a NaN |
| out_is_quiet | output | 1 | Operand was a quiet NaN |
| out_is_signaling | output | 1 | Operand was a signaling NaN |

## Verification
The assertions assume that `in_fmt`, `in_operand` and both mode controls are settled before each rising edge at which `in_valid` is high. They also assume that the mode controls are meant to apply only to the operand sampled with them. The stimulus changes every input only on the falling clock edge, and it pairs each operand with its own polarity and mode setting. It deliberately changes the operand while `in_valid` is low, to show that the held result does not follow it. The vectors cover quiet NaNs, signaling NaNs, infinities, finite values and negative NaNs in all four formats. Some vectors also set the bits above the narrow formats.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

    localparam int NUM_FMT = 4;
    localparam int OP_W    = 64;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_BF16   = 2'd1,
        FMT_SINGLE = 2'd2,
        FMT_DOUBLE = 2'd3
    } fp_fmt_e;

    // Exponent field width per format code
    function automatic int exp_width(input int f);
        case (f)
            0:       return 5;
            1:       return 8;
            2:       return 8;
            default: return 11;
        endcase
    endfunction

    // Fraction field width per format code
    function automatic int frac_width(input int f);
        case (f)
            0:       return 10;
            1:       return 7;
            2:       return 23;
            default: return 52;
        endcase
    endfunction

    // Raw facts pulled from the operand
    typedef struct packed {
        logic exp_ones;
        logic top_frac;
        logic low_frac_nz;
    } nan_fields_t;

    // How the top fraction bit is interpreted
    typedef struct packed {
        logic inverted;
        logic all_quiet;
    } qbit_mode_t;

    // Classification result
    typedef struct packed {
        logic is_nan;
        logic is_quiet;
        logic is_sig;
    } nan_class_t;

endpackage

// File: rtl/nan_field_extract.sv
module nan_field_extract
    import fpnan_pkg::*;
#(
    parameter int OPERAND_W = OP_W
) (
    input  logic [OPERAND_W-1:0] operand,
    input  fp_fmt_e              fmt,
    output nan_fields_t          fields
);

    nan_fields_t per_fmt [NUM_FMT];

    generate
        for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
            localparam int EW = exp_width(g);
            localparam int FW = frac_width(g);
            assign per_fmt[g] = '{
                exp_ones:    &operand[FW+EW-1:FW],
                top_frac:    operand[FW-1],
                low_frac_nz: |operand[FW-2:0]
            };
        end
    endgenerate

    // Sign bits never matter to the classification
    logic unused_sign_bit;
    assign unused_sign_bit = operand[OPERAND_W-1];

    assign fields = per_fmt[fmt];

endmodule

// File: rtl/nan_decide.sv
module nan_decide
    import fpnan_pkg::*;
(
    input  nan_fields_t fields,
    input  qbit_mode_t  mode,
    output nan_class_t  cls
);

    logic any_nan;
    logic top_set_nan;
    logic top_clear_nan;

    always_comb begin
        any_nan       = fields.exp_ones & (fields.top_frac | fields.low_frac_nz);
        top_set_nan   = fields.exp_ones & fields.top_frac;
        top_clear_nan = fields.exp_ones & ~fields.top_frac & fields.low_frac_nz;
        cls.is_nan    = any_nan;
        if (mode.all_quiet) begin
            cls.is_quiet = any_nan;
            cls.is_sig   = 1'b0;
        end else if (mode.inverted) begin
            cls.is_quiet = top_clear_nan;
            cls.is_sig   = top_set_nan;
        end else begin
            cls.is_quiet = top_set_nan;
            cls.is_sig   = top_clear_nan;
        end
    end

endmodule

// File: rtl/nan_result_reg.sv
module nan_result_reg
    import fpnan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  nan_class_t d,
    output logic       valid_q,
    output nan_class_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            q       <= '0;
        end else begin
            valid_q <= load;
            if (load) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/fp_nan_sorter.sv
module fp_nan_sorter
    import fpnan_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      in_fmt,
    input  logic [OP_W-1:0] in_operand,
    input  logic            qbit_inverted,
    input  logic            all_quiet,
    output logic            out_valid,
    output logic            out_is_nan,
    output logic            out_is_quiet,
    output logic            out_is_signaling
);

    nan_fields_t fields;
    qbit_mode_t  mode;
    nan_class_t  cls_now;
    nan_class_t  cls_q;

    assign mode = '{inverted: qbit_inverted, all_quiet: all_quiet};

    nan_field_extract #(.OPERAND_W(OP_W)) u_extract (
        .operand (in_operand),
        .fmt     (fp_fmt_e'(in_fmt)),
        .fields  (fields)
    );

    nan_decide u_decide (
        .fields (fields),
        .mode   (mode),
        .cls    (cls_now)
    );

    nan_result_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (cls_now),
        .valid_q (out_valid),
        .q       (cls_q)
    );

    assign out_is_nan       = cls_q.is_nan;
    assign out_is_quiet     = cls_q.is_quiet;
    assign out_is_signaling = cls_q.is_sig;

endmodule

// File: rtl/nan_sorter_checker.sv
module nan_sorter_checker (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic all_quiet,
    input logic out_valid,
    input logic out_is_nan,
    input logic out_is_quiet,
    input logic out_is_signaling
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1

    AST_NOSIG_MODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && all_quiet) |=> (!out_is_signaling && (out_is_quiet == out_is_nan))); // R6

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(out_is_quiet && out_is_signaling)); // R7

    AST_KIND_IMPLIES_NAN: assert property (@(posedge clk) disable iff (rst)
        (out_is_quiet || out_is_signaling) |-> out_is_nan); // R7

    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_is_nan) && $stable(out_is_quiet) && $stable(out_is_signaling))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_is_nan && !out_is_quiet && !out_is_signaling)); // R9

endmodule

bind fp_nan_sorter nan_sorter_checker u_chk (.*);

// File: tb/tb_fp_nan_sorter.sv
module tb_fp_nan_sorter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic [63:0] in_operand = 64'd0;
    logic        qbit_inverted = 1'b0;
    logic        all_quiet = 1'b0;
    logic        out_valid, out_is_nan, out_is_quiet, out_is_signaling;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] flags;  // {nan, quiet, signaling}
        string      tag;
    } sb_item_t;

    sb_item_t sb_q [$];

    always #2.5 clk = ~clk;

    fp_nan_sorter dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_operand(in_operand), .qbit_inverted(qbit_inverted),
        .all_quiet(all_quiet), .out_valid(out_valid), .out_is_nan(out_is_nan),
        .out_is_quiet(out_is_quiet), .out_is_signaling(out_is_signaling)
    );

    // Reference model written from the field-level rules
    function automatic logic [2:0] model(input logic [1:0] f, input logic [63:0] v,
                                         input logic inv, input logic nq);
        logic q_n, s_n, nan;
        logic [31:0] w;
        logic [63:0] d;
        case (f)
            2'd0: begin
                q_n = (v[14:9] == 6'h3F);
                s_n = (v[14:9] == 6'h3E) && (v[8:0] != 0);
            end
            2'd1: begin
                q_n = (v[14:6] == 9'h1FF);
                s_n = (v[14:6] == 9'h1FE) && (v[5:0] != 0);
            end
            2'd2: begin
                w   = v[31:0] << 1;
                q_n = (w >= 32'hFF80_0000);
                s_n = (v[30:22] == 9'h1FE) && (v[21:0] != 0);
            end
            default: begin
                d   = v << 1;
                q_n = (d >= 64'hFFF0_0000_0000_0000);
                s_n = (v[62:51] == 12'hFFE) && (v[50:0] != 0);
            end
        endcase
        nan = q_n | s_n;
        if (nq)       return {nan, nan, 1'b0};
        else if (inv) return {nan, s_n, q_n};
        else          return {nan, q_n, s_n};
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] f, input logic [63:0] v,
                         input logic inv, input logic nq, input string tag);
        sb_item_t it;
        @(negedge clk);
        in_valid      = 1'b1;
        in_fmt        = f;
        in_operand    = v;
        qbit_inverted = inv;
        all_quiet     = nq;
        it.flags      = model(f, v, inv, nq);
        it.tag        = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares each registered result with the queue head
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check("R1 unexpected out_valid", 3'b001, 3'b000);
                end else begin
                    it = sb_q.pop_front();
                    check(it.tag, {out_is_nan, out_is_quiet, out_is_signaling}, it.flags);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [63:0] vec_v [20];
    logic [1:0]  vec_f [20];

    initial begin
        vec_f[0]  = 2'd0; vec_v[0]  = 64'h0000_0000_0000_7E00; // half quiet-pattern
        vec_f[1]  = 2'd0; vec_v[1]  = 64'h0000_0000_0000_7C01; // half low-only
        vec_f[2]  = 2'd0; vec_v[2]  = 64'h0000_0000_0000_7C00; // half inf
        vec_f[3]  = 2'd0; vec_v[3]  = 64'hDEAD_BEEF_0000_FE00; // half neg, upper junk
        vec_f[4]  = 2'd0; vec_v[4]  = 64'hFFFF_FFFF_FFFF_3C00; // half 1.0, upper ones
        vec_f[5]  = 2'd1; vec_v[5]  = 64'h0000_0000_0000_7FC0;
        vec_f[6]  = 2'd1; vec_v[6]  = 64'h0000_0000_0000_7F81;
        vec_f[7]  = 2'd1; vec_v[7]  = 64'h0000_0000_0000_7F80;
        vec_f[8]  = 2'd1; vec_v[8]  = 64'h1234_5678_9ABC_FFA0;
        vec_f[9]  = 2'd2; vec_v[9]  = 64'h0000_0000_7FC0_0000;
        vec_f[10] = 2'd2; vec_v[10] = 64'h0000_0000_7F80_0001;
        vec_f[11] = 2'd2; vec_v[11] = 64'h0000_0000_7F80_0000;
        vec_f[12] = 2'd2; vec_v[12] = 64'hFFFF_FFFF_3F80_0000;
        vec_f[13] = 2'd2; vec_v[13] = 64'h0000_0000_FFBF_FFFF;
        vec_f[14] = 2'd3; vec_v[14] = 64'h7FF8_0000_0000_0000;
        vec_f[15] = 2'd3; vec_v[15] = 64'h7FF0_0000_0000_0001;
        vec_f[16] = 2'd3; vec_v[16] = 64'h7FF0_0000_0000_0000;
        vec_f[17] = 2'd3; vec_v[17] = 64'hFFF4_0000_0000_0000;
        vec_f[18] = 2'd3; vec_v[18] = 64'h3FF0_0000_0000_0000;
        vec_f[19] = 2'd2; vec_v[19] = 64'h0000_0000_0000_7E00; // half qNaN bits read as single
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset outputs", {out_valid, out_is_nan, out_is_quiet, out_is_signaling} == 4'b0 ? 3'b000 : 3'b111, 3'b000);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4: normal polarity across formats
        for (int i = 0; i < 20; i++) drive(vec_f[i], vec_v[i], 1'b0, 1'b0, "R2 R3 R4 normal polarity");
        // R5: inverted polarity
        for (int i = 0; i < 20; i++) drive(vec_f[i], vec_v[i], 1'b1, 1'b0, "R5 inverted polarity");
        // R6: all NaNs quiet, both polarities
        for (int i = 0; i < 20; i++) drive(vec_f[i], vec_v[i], i[0], 1'b1, "R6 all quiet mode");
        // R7: back-to-back class changes
        drive(2'd3, 64'h7FF0_0000_0000_0001, 1'b0, 1'b0, "R7 signaling then quiet");
        drive(2'd3, 64'h7FF8_0000_0000_0000, 1'b0, 1'b0, "R7 quiet after signaling");

        // R8: hold while idle, with a changed operand
        drive(2'd2, 64'h0000_0000_7F80_0001, 1'b0, 1'b0, "R8 setup signaling");
        @(negedge clk);
        in_valid   = 1'b0;
        in_operand = 64'h0000_0000_7FC0_0000;
        all_quiet  = 1'b1;
        @(posedge clk);
        #1;
        check("R1 out_valid low when idle", {2'b00, out_valid}, 3'b000);
        @(posedge clk);
        #1;
        check("R8 flags held while idle", {out_is_nan, out_is_quiet, out_is_signaling}, 3'b101);

        // R1: drain the queue
        repeat (3) @(posedge clk);
        #1;
        check("R1 scoreboard drained", {2'b00, sb_q.size() != 0}, 3'b000);

        // R9: reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9 reset clears flags", {out_is_nan, out_is_quiet, out_is_signaling}, 3'b000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule